// File: doc/BRIEF.md
# DRAM Termination Update Sequencer

This block sits in a memory controller and drives the on-die termination enable pin of a DDR2-class device. While it is idle, the pin follows the level that the controller requests. The pin is held low whenever the device reports self-refresh, because termination is not available in that state.

The block also changes the device's nominal termination strength, which is set through an extended mode-register write. A change follows a fixed order:
- Force the termination pin low.
- Wait out the turn-off delay.
- Wait for a command-slot grant, then issue the write with the encoded termination field.
- Keep the pin low until the longest mode-update time has passed, because the termination value is undefined during that time.
- Hand the pin back to the requested level.

A request that arrives while a change is running is held and served afterwards. A request for the setting already in place ends without any command.

Top module: `odt_rtt_sequencer`

## Requirements
- R1: After reset, `odt_pin`, `busy` and `emrs_strobe` are low and the stored setting is "disabled". A following request for code 0 therefore issues no command.
- R2: When idle and not in self-refresh, `odt_pin` equals `odt_req` in the same cycle.
- R3: While `self_refresh` is high, `odt_pin` is low whatever `odt_req` is.
- R4: Request codes are 0 = disabled, 1 = 50 ohm, 2 = 75 ohm and 3 = 150 ohm. With `emrs_strobe`, `emrs_rtt_field` carries 2'b00, 2'b11, 2'b01 and 2'b10 for these codes, in that order.
- R5: `busy` is high from the cycle the pin is forced low until the sequence returns to idle, and `odt_pin` is low in every busy cycle.
- R6: `emrs_strobe` comes no earlier than T_AOFD+1 cycles after the first busy cycle. With the grant held high it comes exactly then.
- R7: `emrs_strobe` is asserted only in a cycle where `cmd_grant` is high. Without a grant, the block stays busy with the pin low.
- R8: Let M be the larger of T_MOD_MIN and T_MOD_MAX. After a strobe in cycle s, the pin stays low through cycle s+M+1 and can follow `odt_req` again from cycle s+M+2.
- R9: A request that arrives while busy is kept and served after the current sequence. A later request replaces an earlier one that has not yet been served.
- R10: A request equal to the stored setting completes with no command, and `busy` stays low.
- R11: `emrs_strobe` lasts exactly one cycle, and there is one strobe per change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odt_req | input | 1 | Requested termination pin level |
| rtt_req_valid | input | 1 | Strobe for a new termination request |
| rtt_req_code | input | 2 | Requested strength (0 disabled, 1 50, 2 75, 3 150 ohm) |
| self_refresh | input | 1 | Device is in self-refresh |
| cmd_grant | input | 1 | Command slot available this cycle |
| odt_pin | output | 1 | Termination enable pin level |
| emrs_strobe | output | 1 | Extended mode-register write command |
| emrs_rtt_field | output | 2 | Encoded termination field sent with the command |
| busy | output | 1 | Update sequence in progress |

## Verification
The bench builds the block with T_AOFD=3, T_MOD_MIN=2, T_MOD_MAX=5 and a 4-bit counter. With these values every wait finishes within a few cycles, so the exact strobe cycle (first busy cycle + 4) and the exact pin return (strobe + 7) can be compared cycle by cycle. The short windows also let the bench run a withheld grant, a request queued during a sequence, a replaced pending request and a same-value request in one short run. Setting the minimum update time below the maximum checks that the hold window is taken from the larger value.

// File: rtl/odt_seq_pkg.sv
package odt_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FORCE_LOW,
    SQ_AOFD_WAIT,
    SQ_MRS_ISSUE,
    SQ_MOD_WAIT,
    SQ_RESTORE
  } seq_state_t;

  // request code -> two-bit mode-register termination field
  function automatic logic [1:0] rtt_field(input logic [1:0] sel);
    case (sel)
      2'd1:    rtt_field = 2'b11;  // 50 ohm
      2'd2:    rtt_field = 2'b01;  // 75 ohm
      2'd3:    rtt_field = 2'b10;  // 150 ohm
      default: rtt_field = 2'b00;  // disabled
    endcase
  endfunction

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    cyc_max = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/odt_req_latch.sv
module odt_req_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_code,
  input  logic       take,
  output logic       pend_vld,
  output logic [1:0] pend_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_code <= 2'd0;
    end else if (req_valid) begin
      pend_vld  <= 1'b1;        // newest request wins
      pend_code <= req_code;
    end else if (take) begin
      pend_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/odt_delay_timer.sv
module odt_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  // high in the last cycle of a window that lasts load_val cycles
  assign expired = (cnt == CNT_W'(1));
endmodule

// File: rtl/odt_rtt_sequencer.sv
module odt_rtt_sequencer
  import odt_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int T_AOFD    = 3,
  parameter int T_MOD_MIN = 6,
  parameter int T_MOD_MAX = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odt_req,
  input  logic       rtt_req_valid,
  input  logic [1:0] rtt_req_code,
  input  logic       self_refresh,
  input  logic       cmd_grant,
  output logic       odt_pin,
  output logic       emrs_strobe,
  output logic [1:0] emrs_rtt_field,
  output logic       busy
);
  localparam int T_MOD_WAIT = int'(cyc_max(T_MOD_MIN, T_MOD_MAX));

  seq_state_t       state, state_nx;
  logic [1:0]       cur_code, tgt_code;
  logic             pend_vld;
  logic [1:0]       pend_code;
  logic             take;
  logic             start_seq;   // named event: a real change begins
  logic             cmd_fire;    // named event: mode write goes out
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  odt_req_latch u_pend (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rtt_req_valid), .req_code(rtt_req_code),
    .take(take), .pend_vld(pend_vld), .pend_code(pend_code)
  );

  odt_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  always_comb begin
    state_nx  = state;
    take      = 1'b0;
    start_seq = 1'b0;
    cmd_fire  = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = CNT_W'(T_AOFD);
    case (state)
      SQ_IDLE: begin
        take = pend_vld;
        if (pend_vld && pend_code != cur_code) begin
          start_seq = 1'b1;
          state_nx  = SQ_FORCE_LOW;
        end
      end
      SQ_FORCE_LOW: begin
        tmr_load = 1'b1;
        state_nx = SQ_AOFD_WAIT;
      end
      SQ_AOFD_WAIT: if (tmr_expired) state_nx = SQ_MRS_ISSUE;
      SQ_MRS_ISSUE: begin
        if (cmd_grant) begin
          cmd_fire = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_MOD_WAIT);
          state_nx = SQ_MOD_WAIT;
        end
      end
      SQ_MOD_WAIT: if (tmr_expired) state_nx = SQ_RESTORE;
      SQ_RESTORE:  state_nx = SQ_IDLE;
      default:     state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cur_code <= 2'd0;
      tgt_code <= 2'd0;
    end else begin
      state <= state_nx;
      if (start_seq) tgt_code <= pend_code;
      if (cmd_fire)  cur_code <= tgt_code;
    end
  end

  assign busy           = (state != SQ_IDLE);
  assign odt_pin        = odt_req && !self_refresh && !busy;
  assign emrs_strobe    = cmd_fire;
  assign emrs_rtt_field = cmd_fire ? rtt_field(tgt_code) : 2'b00;
endmodule

// File: rtl/odt_seq_checker.sv
module odt_seq_checker #(
  parameter int AOFD_CYC = 3,
  parameter int MOD_CYC  = 12
) (
  input logic clk,
  input logic rst_n,
  input logic self_refresh,
  input logic cmd_grant,
  input logic odt_pin,
  input logic emrs_strobe,
  input logic busy
);
  localparam logic [15:0] LOW_MIN = 16'(AOFD_CYC + 1);
  localparam logic [15:0] HOLD_TOP = 16'(MOD_CYC + 1);

  logic [15:0] low_cnt, since_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      since_cmd <= '0;
    end else begin
      if (!busy)                  low_cnt <= '0;
      else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
      if (emrs_strobe)            since_cmd <= 16'd1;
      else if (since_cmd != '0 && since_cmd < HOLD_TOP) since_cmd <= since_cmd + 1'b1;
      else                        since_cmd <= '0;
    end
  end

  p_sr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh |-> !odt_pin);
  p_busy_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !odt_pin);
  p_cmd_in_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emrs_strobe |-> busy);
  p_aofd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emrs_strobe |-> (low_cnt >= LOW_MIN));
  p_grant_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    emrs_strobe |-> cmd_grant);
  p_mod_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_cmd != '0) |-> (busy && !odt_pin));
  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    emrs_strobe |=> !emrs_strobe);
endmodule

bind odt_rtt_sequencer odt_seq_checker #(
  .AOFD_CYC(T_AOFD),
  .MOD_CYC(T_MOD_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .self_refresh(self_refresh),
  .cmd_grant(cmd_grant), .odt_pin(odt_pin),
  .emrs_strobe(emrs_strobe), .busy(busy)
);

// File: tb/tb_odt_rtt_sequencer.sv
`timescale 1ns/1ps
module tb_odt_rtt_sequencer;
  localparam int AOFD = 3;
  localparam int MMIN = 2;
  localparam int MMAX = 5;
  localparam int MWIN = (MMIN > MMAX) ? MMIN : MMAX;

  logic clk = 1'b0, rst_n = 1'b0;
  logic odt_req = 1'b0, rtt_req_valid = 1'b0, self_refresh = 1'b0, cmd_grant = 1'b0;
  logic [1:0] rtt_req_code = 2'd0;
  logic odt_pin, emrs_strobe, busy;
  logic [1:0] emrs_rtt_field;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  bit exact_gap = 1;
  logic [1:0] exp_q[$];

  odt_rtt_sequencer #(.CNT_W(4), .T_AOFD(AOFD), .T_MOD_MIN(MMIN), .T_MOD_MAX(MMAX)) dut (
    .clk(clk), .rst_n(rst_n), .odt_req(odt_req), .rtt_req_valid(rtt_req_valid),
    .rtt_req_code(rtt_req_code), .self_refresh(self_refresh), .cmd_grant(cmd_grant),
    .odt_pin(odt_pin), .emrs_strobe(emrs_strobe), .emrs_rtt_field(emrs_rtt_field), .busy(busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // bench restatement of the field encoding
  function automatic logic [1:0] want_field(input logic [1:0] c);
    logic [1:0] lut [4];
    lut[0] = 2'b00; lut[1] = 2'b11; lut[2] = 2'b01; lut[3] = 2'b10;
    return lut[c];
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_rtt(input logic [1:0] c);
    @(posedge clk); #1;
    rtt_req_valid = 1'b1; rtt_req_code = c;
    @(posedge clk); #1;
    rtt_req_valid = 1'b0;
  endtask

  task automatic expect_cmd(input logic [1:0] c);
    exp_q.push_back(want_field(c));
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
    #1;
  endtask

  // monitor / scoreboard
  bit busy_d = 0, odt_d = 0, watch_rise = 0;
  int rise_cyc = 0, strobe_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy && !busy_d) rise_cyc = cyc;
      if (self_refresh) chk(!odt_pin, "R3 pin low in self-refresh", odt_pin, 0);
      if (busy) chk(!odt_pin, "R5 pin low while busy", odt_pin, 0);
      if (emrs_strobe) begin
        chk(cmd_grant, "R7 strobe without grant", cmd_grant, 1);
        if (exp_q.size() == 0) chk(0, "R11 unexpected strobe", 1, 0);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(emrs_rtt_field == e, "R4 field", emrs_rtt_field, e);
        end
        if (exact_gap) chk(cyc - rise_cyc == AOFD + 1, "R6 strobe gap", cyc - rise_cyc, AOFD + 1);
        else chk(cyc - rise_cyc >= AOFD + 1, "R6 strobe gap min", cyc - rise_cyc, AOFD + 1);
        strobe_cyc = cyc;
        watch_rise = 1;
      end
      if (watch_rise && odt_pin && !odt_d) begin
        chk(cyc - strobe_cyc == MWIN + 2, "R8 pin return", cyc - strobe_cyc, MWIN + 2);
        watch_rise = 0;
      end
      busy_d = busy;
      odt_d  = odt_pin;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit saw;
    int n0;
    step(4);
    #1;
    chk(!odt_pin && !busy && !emrs_strobe, "R1 reset outputs", {odt_pin, busy, emrs_strobe}, 0);
    rst_n = 1'b1;
    step(2);

    // R2: follow when idle
    odt_req = 1'b1; #1;
    chk(odt_pin == 1'b1, "R2 follow high", odt_pin, 1);
    odt_req = 1'b0; #1;
    chk(odt_pin == 1'b0, "R2 follow low", odt_pin, 0);

    // R3: self-refresh suppression
    odt_req = 1'b1; self_refresh = 1'b1; step(3);
    chk(odt_pin == 1'b0, "R3 suppressed", odt_pin, 0);
    self_refresh = 1'b0; #1;
    chk(odt_pin == 1'b1, "R3 released", odt_pin, 1);

    // R1/R10: code 0 equals reset setting -> no sequence
    saw = 0;
    send_rtt(2'd0);
    repeat (12) begin @(negedge clk); if (busy) saw = 1; end
    chk(!saw, "R10 R1 no sequence for stored value", saw, 0);

    // R4 R6 R8: full change with grant held
    cmd_grant = 1'b1;
    expect_cmd(2'd2);
    send_rtt(2'd2);
    wait_quiet();
    chk(exp_q.size() == 0, "R4 command for 75 ohm seen", exp_q.size(), 0);

    // R7: grant withheld
    cmd_grant = 1'b0; exact_gap = 0;
    expect_cmd(2'd3);
    send_rtt(2'd3);
    step(20);
    chk(busy == 1'b1, "R7 waits busy without grant", busy, 1);
    chk(exp_q.size() == 1, "R7 no command without grant", exp_q.size(), 1);
    chk(odt_pin == 1'b0, "R7 pin low while waiting", odt_pin, 0);
    cmd_grant = 1'b1;
    wait_quiet();
    chk(exp_q.size() == 0, "R7 command after grant", exp_q.size(), 0);
    exact_gap = 1;

    // R9: queue during busy, newer pending replaces older
    expect_cmd(2'd1);
    expect_cmd(2'd0);
    send_rtt(2'd1);
    step(3);
    chk(busy == 1'b1, "R9 first sequence running", busy, 1);
    send_rtt(2'd2);
    send_rtt(2'd0);
    wait_quiet();
    chk(exp_q.size() == 0, "R9 queued request served", exp_q.size(), 0);

    // R10: same as stored (disabled)
    saw = 0;
    send_rtt(2'd0);
    repeat (12) begin @(negedge clk); if (busy) saw = 1; end
    chk(!saw, "R10 equal request no busy", saw, 0);

    // R4/R11: remaining code 150 then 50, count strobes
    n0 = total;
    expect_cmd(2'd3);
    send_rtt(2'd3);
    wait_quiet();
    expect_cmd(2'd1);
    send_rtt(2'd1);
    wait_quiet();
    chk(exp_q.size() == 0, "R11 one strobe per change", exp_q.size(), 0);
    chk(total > n0, "R4 checks made", total - n0, 1);

    step(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule